// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block is the register and control core of a four-channel digital resistor divider. Each channel has a live 7-bit tap register that drives the switch array. Each channel also has a stored start-up value, held in an emulated non-volatile cell. Three further non-volatile bytes serve as general scratch storage. One control byte selects which of the two register sets a channel address reaches, gates a shutdown output, and reports a busy flag. A serial front end drives the block through a plain address/data bus with separate write and read strobes. Read data is registered.

Power-up reset puts every tap at mid-scale. When the memory-ready input is high, the block loads each tap once from its stored start-up value. A write to a non-volatile cell takes a fixed number of clock cycles. During that time all register writes are refused. The emulated cells survive the power-up reset. A separate initialization input clears them.

Top module: `wiper_ctrl_core`

## Requirements
- R1: Channel c's tap value appears on `wiper_pos[7c+6:7c]`. 7'h00 is the tap nearest the low end and 7'h7F the tap nearest the high end.
- R2: While `rst` is high, every tap loads 7'h40 at each clock edge. The control byte reads 8'h40: target bit 7 = 0, shutdown-enable bit 6 = 1, busy bit 5 = 0.
- R3: After `rst` falls, the first clock edge with `nv_ready` high copies each stored start-up value into its tap. This happens only once per reset.
- R4: Address map. 0-3 are channels 0-3, 4-6 are general bytes, and 8 is the control byte. A read of 7 or of 9-15 returns 8'h00, and a write to those addresses changes nothing.
- R5: With control bit 7 = 1, a channel write updates only the tap and starts no busy period. A channel read returns the tap.
- R6: With control bit 7 = 0, a channel write puts data[6:0] into the tap at the next edge. The stored value changes only when the busy period ends. A channel read returns the stored value.
- R7: A non-volatile write (channel with bit 7 = 0, or a general byte) holds control bit 5 at 1 for exactly `NV_WRITE_CYCLES` cycles. Writing bit 5 has no effect.
- R8: While bit 5 is 1, writes to addresses 0-6 and 8 are ignored.
- R9: `shutdown` is 1 unless both control bit 6 and `shdn_n_pin` are 1.
- R10: Control bits 4:0 read as 0. Channel reads return 0 in bit 7.
- R11: Stored values and general bytes survive `rst`. A high `nv_init` clears them to 0 and cancels any pending non-volatile write.
- R12: A host write to a tap in the same cycle as the start-up load takes priority for that channel. The other channels still load.
- R13: `host_rdata` updates one edge after a cycle with `host_re` high and holds otherwise. It is 8'h00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| nv_init | input | 1 | Clears the emulated non-volatile cells |
| nv_ready | input | 1 | Non-volatile cells are readable; enables the start-up load |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_re | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| shdn_n_pin | input | 1 | External shutdown request, active low |
| shutdown | output | 1 | Channels in shutdown |
| wiper_pos | output | 28 | Four packed 7-bit tap values, channel 0 lowest |

## Verification
The start-up load and a host tap write can land on the same clock edge. The bench provokes this by holding `nv_ready` low through a reset. It then raises `nv_ready` in the same cycle it writes channel 1. The expected taps are then the host value on channel 1 and the reloaded stored values on the others. A second collision is a write that arrives while the busy count is running. The bench issues channel and control writes mid-count and sees no change at the taps or on control read-back. It also sweeps control reads cycle by cycle to count exactly how long the busy bit stays high.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int NUM_CH    = 4;
    localparam int WIPER_W   = 7;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int NUM_GP    = 3;
    localparam int NUM_NV    = NUM_CH + NUM_GP;
    localparam int NV_IDX_W  = $clog2(NUM_NV);
    localparam int CH_IDX_W  = $clog2(NUM_CH);

    localparam logic [ADDR_W-1:0]  ADDR_CTRL = ADDR_W'(8);
    localparam logic [WIPER_W-1:0] TAP_MID   = WIPER_W'(64);

    typedef enum logic [1:0] {
        RGN_CHAN,
        RGN_GP,
        RGN_CTRL,
        RGN_NONE
    } region_e;

    typedef struct packed {
        region_e               region;
        logic [NV_IDX_W-1:0]   nv_idx;
    } decode_t;

    typedef struct packed {
        logic to_tap;     // 1: channel accesses reach the live tap only
        logic run_en;     // 0: force shutdown
    } ctrl_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.nv_idx = a[NV_IDX_W-1:0];
        if (int'(a) < NUM_CH)
            d.region = RGN_CHAN;
        else if (int'(a) < NUM_NV)
            d.region = RGN_GP;
        else if (a == ADDR_CTRL)
            d.region = RGN_CTRL;
        else
            d.region = RGN_NONE;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input ctrl_t c, input logic busy);
        return {c.to_tap, c.run_en, busy, {(DATA_W-3){1'b0}}};
    endfunction

endpackage

// File: rtl/wiper_nv_store.sv
module wiper_nv_store
    import wiper_pkg::*;
#(
    parameter int WRITE_CYCLES = 20
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             nv_init,
    input  logic                             start_i,
    input  logic [NV_IDX_W-1:0]              start_idx,
    input  logic [DATA_W-1:0]                start_data,
    output logic                             busy_o,
    output logic [NUM_NV-1:0][DATA_W-1:0]    nv_q
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0]    remain;
    logic [NV_IDX_W-1:0] pend_idx;
    logic [DATA_W-1:0]   pend_data;

    assign busy_o = (remain != '0);

    always_ff @(posedge clk) begin
        if (nv_init) begin
            nv_q   <= '0;
            remain <= '0;
        end else if (rst) begin
            remain <= '0;
        end else if (start_i && !busy_o) begin
            remain    <= CNT_W'(WRITE_CYCLES);
            pend_idx  <= start_idx;
            pend_data <= start_data;
        end else if (busy_o) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1))
                nv_q[pend_idx] <= pend_data;
        end
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst || nv_init)
        (start_i && !busy_o) |=> busy_o); // R7

    AST_CELLS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst || nv_init)
        (!busy_o && !start_i) |=> $stable(nv_q)); // R11

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wiper_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              nv_ready,
    input  logic [NUM_CH-1:0][WIPER_W-1:0]    start_val,
    input  logic                              wr_en,
    input  logic [CH_IDX_W-1:0]               wr_ch,
    input  logic [WIPER_W-1:0]                wr_data,
    output logic [NUM_CH-1:0][WIPER_W-1:0]    tap_q
);

    logic                load_pending;
    logic                do_load;
    logic [WIPER_W-1:0]  tap_r [NUM_CH];

    assign do_load = load_pending && nv_ready;

    always_ff @(posedge clk) begin
        if (rst)
            load_pending <= 1'b1;
        else if (nv_ready)
            load_pending <= 1'b0;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst)
                tap_r[ch] <= TAP_MID;
            else if (wr_en && wr_ch == CH_IDX_W'(ch))
                tap_r[ch] <= wr_data;
            else if (do_load)
                tap_r[ch] <= start_val[ch];
        end
        assign tap_q[ch] = tap_r[ch];

        AST_TAP_MID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> tap_q[ch] == TAP_MID); // R2
    end

    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (rst)
        !load_pending |=> !load_pending); // R3

endmodule

// File: rtl/wiper_ctrl_core.sv
module wiper_ctrl_core
    import wiper_pkg::*;
#(
    parameter int NV_WRITE_CYCLES = 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         nv_init,
    input  logic                         nv_ready,
    input  logic [ADDR_W-1:0]            host_addr,
    input  logic [DATA_W-1:0]            host_wdata,
    input  logic                         host_we,
    input  logic                         host_re,
    output logic [DATA_W-1:0]            host_rdata,
    input  logic                         shdn_n_pin,
    output logic                         shutdown,
    output logic [NUM_CH*WIPER_W-1:0]    wiper_pos
);

    decode_t                           dec;
    ctrl_t                             ctrl;
    logic                              busy;
    logic                              wr_ok;
    logic                              nv_start;
    logic [DATA_W-1:0]                 nv_wdata;
    logic [NUM_NV-1:0][DATA_W-1:0]     nv_q;
    logic [NUM_CH-1:0][WIPER_W-1:0]    start_val;
    logic [NUM_CH-1:0][WIPER_W-1:0]    tap_q;
    logic [CH_IDX_W-1:0]               ch_sel;
    logic [DATA_W-1:0]                 rd_next;

    assign dec    = decode_addr(host_addr);
    assign ch_sel = host_addr[CH_IDX_W-1:0];
    assign wr_ok  = host_we && !busy;

    // control byte
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.to_tap <= 1'b0;
            ctrl.run_en <= 1'b1;
        end else if (wr_ok && dec.region == RGN_CTRL) begin
            ctrl.to_tap <= host_wdata[DATA_W-1];
            ctrl.run_en <= host_wdata[DATA_W-2];
        end
    end

    // non-volatile write launch
    assign nv_start = wr_ok && ((dec.region == RGN_CHAN && !ctrl.to_tap) ||
                                 dec.region == RGN_GP);
    assign nv_wdata = (dec.region == RGN_CHAN) ? {1'b0, host_wdata[WIPER_W-1:0]}
                                               : host_wdata;

    wiper_nv_store #(
        .WRITE_CYCLES (NV_WRITE_CYCLES)
    ) u_nv (
        .clk        (clk),
        .rst        (rst),
        .nv_init    (nv_init),
        .start_i    (nv_start),
        .start_idx  (dec.nv_idx),
        .start_data (nv_wdata),
        .busy_o     (busy),
        .nv_q       (nv_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_start
        assign start_val[c] = nv_q[c][WIPER_W-1:0];
    end

    wiper_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .nv_ready  (nv_ready),
        .start_val (start_val),
        .wr_en     (wr_ok && dec.region == RGN_CHAN),
        .wr_ch     (ch_sel),
        .wr_data   (host_wdata[WIPER_W-1:0]),
        .tap_q     (tap_q)
    );

    assign wiper_pos = tap_q;

    // read path
    always_comb begin
        rd_next = '0;
        case (dec.region)
            RGN_CHAN: rd_next = ctrl.to_tap ? {1'b0, tap_q[ch_sel]}
                                            : {1'b0, start_val[ch_sel]};
            RGN_GP:   rd_next = nv_q[dec.nv_idx];
            RGN_CTRL: rd_next = ctrl_image(ctrl, busy);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_re)
            host_rdata <= rd_next;
    end

    assign shutdown = !(ctrl.run_en && shdn_n_pin);

    AST_BUSY_FREEZES_CTRL: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we) |=> $stable(ctrl)); // R8

    AST_CTRL_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_re && host_addr == ADDR_CTRL) |=> host_rdata[4:0] == 5'd0); // R10

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_re && dec.region == RGN_NONE) |=> host_rdata == '0); // R4

    AST_PIN_FORCES_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        !shdn_n_pin |-> shutdown); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !host_re |=> $stable(host_rdata)); // R13

endmodule

// File: tb/wiper_ctrl_core_tb.sv
module wiper_ctrl_core_tb;

    localparam int N   = 12;
    localparam int PER = 8;

    logic        clk = 1'b0;
    logic        rst, nv_init, nv_ready;
    logic [3:0]  host_addr;
    logic [7:0]  host_wdata;
    logic        host_we, host_re;
    logic [7:0]  host_rdata;
    logic        shdn_n_pin;
    logic        shutdown;
    logic [27:0] wiper_pos;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    wiper_ctrl_core #(.NV_WRITE_CYCLES(N)) u_dut (
        .clk(clk), .rst(rst), .nv_init(nv_init), .nv_ready(nv_ready),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata),
        .shdn_n_pin(shdn_n_pin), .shutdown(shutdown), .wiper_pos(wiper_pos)
    );

    // behavioural reference model
    int   m_tap [4];
    int   m_nv  [7];
    bit   m_tgt, m_run, m_load;
    int   m_cnt, m_pidx, m_pdata;
    int   m_rd;

    function automatic int model_read(input int a);
        if (a < 4)       return m_tgt ? m_tap[a] : (m_nv[a] & 8'h7F);
        else if (a < 7)  return m_nv[a];
        else if (a == 8) return (m_tgt << 7) | (m_run << 6) | ((m_cnt != 0) << 5);
        else             return 0;
    endfunction

    always @(posedge clk) begin : model
        int  a, rv;
        bit  busy_pre, acc, start;
        a        = int'(host_addr);
        busy_pre = (m_cnt != 0);
        acc      = host_we && !busy_pre;
        rv       = model_read(a);
        start    = acc && ((a < 4 && !m_tgt) || (a >= 4 && a < 7));
        if (rst) begin
            for (int i = 0; i < 4; i++) m_tap[i] = 64;
            m_tgt = 0; m_run = 1; m_load = 1; m_rd = 0;
        end else begin
            if (host_re) m_rd = rv;
            for (int i = 0; i < 4; i++) begin
                if (acc && a == i)               m_tap[i] = host_wdata & 8'h7F;
                else if (m_load && nv_ready)     m_tap[i] = m_nv[i] & 8'h7F;
            end
            if (nv_ready) m_load = 0;
            if (acc && a == 8) begin
                m_tgt = host_wdata[7];
                m_run = host_wdata[6];
            end
        end
        if (nv_init) begin
            for (int i = 0; i < 7; i++) m_nv[i] = 0;
            m_cnt = 0;
        end else if (rst) begin
            m_cnt = 0;
        end else if (start) begin
            m_cnt = N; m_pidx = a;
            m_pdata = (a < 4) ? (host_wdata & 8'h7F) : int'(host_wdata);
        end else if (m_cnt != 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_nv[m_pidx] = m_pdata;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            int exp_pos;
            exp_pos = 0;
            for (int i = 0; i < 4; i++) exp_pos |= (m_tap[i] & 8'h7F) << (7*i);
            check("R1 tap bus vs model", int'(wiper_pos), exp_pos);
            check("R9 shutdown vs model", int'(shutdown), int'(!(m_run && shdn_n_pin)));
            check("R13 rdata vs model", int'(host_rdata), m_rd);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        host_addr = 4'(a); host_wdata = 8'(d); host_we = 1'b1;
        tick(1);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        host_addr = 4'(a); host_re = 1'b1;
        tick(1);
        host_re = 1'b0;
        check(tag, int'(host_rdata), exp);
    endtask

    initial begin
        #(PER*200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int busy_seen;
        rst = 1; nv_init = 1; nv_ready = 0; shdn_n_pin = 1;
        host_addr = 0; host_wdata = 0; host_we = 0; host_re = 0;
        #2;
        tick(3);
        nv_init = 0;
        tick(1);
        cmp_on = 1;
        rst = 0;
        check("R2 taps at mid", int'(wiper_pos), {4{7'h40}});
        rd_chk(8, 8'h40, "R2 control reset image");

        nv_ready = 1;
        tick(1);
        check("R3 load from cleared cells", int'(wiper_pos), 0);

        // non-volatile channel write
        wr(0, 8'h95);
        check("R6 tap takes new value at once", int'(wiper_pos[6:0]), 8'h15);
        rd_chk(8, 8'h60, "R7 busy visible");
        rd_chk(0, 8'h00, "R6 stored value not yet committed");
        wr(1, 8'h22);
        check("R8 tap write refused while busy", int'(wiper_pos[13:7]), 0);
        wr(8, 8'hC0);
        rd_chk(8, 8'h60, "R8 control write refused while busy");
        tick(N);
        rd_chk(8, 8'h40, "R7 busy cleared");
        rd_chk(0, 8'h15, "R6 stored value committed");

        // exact busy length on a general byte
        wr(5, 8'hA5);
        host_addr = 4'd8; host_re = 1'b1;
        busy_seen = 0;
        for (int k = 0; k < N + 4; k++) begin
            tick(1);
            if (host_rdata[5]) busy_seen++;
        end
        host_re = 1'b0;
        check("R7 busy length", busy_seen, N);
        rd_chk(5, 8'hA5, "R4 general byte 5");
        wr(4, 8'h3C); tick(N + 1);
        wr(6, 8'hFF); tick(N + 1);
        rd_chk(4, 8'h3C, "R4 general byte 4");
        rd_chk(6, 8'hFF, "R4 general byte 6");

        // unmapped addresses
        wr(7, 8'h55);
        rd_chk(7, 8'h00, "R4 reserved read");
        wr(12, 8'h5A);
        rd_chk(12, 8'h00, "R4 unmapped read");
        rd_chk(8, 8'h40, "R4 unmapped write starts nothing");
        tick(3);
        check("R13 rdata held", int'(host_rdata), 8'h40);

        // volatile-only target
        wr(8, 8'hE0);
        rd_chk(8, 8'hC0, "R7 busy bit not writable, R10 low bits zero");
        wr(2, 8'hB3);
        check("R5 tap written directly", int'(wiper_pos[20:14]), 8'h33);
        rd_chk(8, 8'hC0, "R5 no busy period");
        rd_chk(2, 8'h33, "R10 channel read bit7 zero");
        wr(8, 8'h40);
        rd_chk(2, 8'h00, "R5 stored value untouched");

        // shutdown
        check("R9 normal run", int'(shutdown), 0);
        shdn_n_pin = 0; #1;
        check("R9 pin low", int'(shutdown), 1);
        shdn_n_pin = 1;
        wr(8, 8'h00);
        check("R9 enable bit low", int'(shutdown), 1);
        wr(8, 8'h40);
        check("R9 back to run", int'(shutdown), 0);

        // reload collides with host write
        nv_ready = 0; rst = 1;
        tick(2);
        check("R2 mid after second reset", int'(wiper_pos), {4{7'h40}});
        rst = 0;
        tick(1);
        nv_ready = 1;
        wr(1, 8'h7F);
        check("R12 host wins on channel 1", int'(wiper_pos), {7'h00, 7'h00, 7'h7F, 7'h15});
        rd_chk(5, 8'hA5, "R11 general byte survives reset");
        tick(N + 2);
        rd_chk(1, 8'h7F, "R6 channel 1 stored");

        // initialization clears cells
        nv_init = 1; tick(1); nv_init = 0;
        rd_chk(0, 8'h00, "R11 cleared channel 0");
        rd_chk(6, 8'h00, "R11 cleared general byte");
        rst = 1; tick(1); rst = 0; tick(1);
        check("R3 reload of cleared cells", int'(wiper_pos), 0);
        tick(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule